// File: doc/BRIEF.md
# Word-Parallel Stuck-At Fault Simulation Engine

This block runs one pass of bit-parallel stuck-at fault simulation over a small combinational netlist. The netlist is held in a writable gate table, and every net of the netlist is a `WORD_W`-bit word. Bit 0 of each word models the circuit with no fault. Every other bit position models a copy of the circuit that carries exactly one injected stuck-at fault. The gate table is loaded through a write port, one gate per entry, in level order. A driving loop then supplies an input pattern and a group of up to `WORD_W-1` fault sites, and pulses `start`.

The engine broadcasts the pattern into all bit positions of the primary-input nets. It then evaluates the gate table in order, one entry per clock, as a word-wide logic operation. Stuck-at forcing is applied per bit position, either on a whole net (the stem) or on one input pin of one gate (a fanout branch). At the end of the pass it compares every marked primary output against its fault-free bit. The result is one detected bit per fault slot, ORed across the outputs, and `done` goes high.

The driving loop steps through fault groups, ceil(faults / (WORD_W-1)) passes per pattern. It drops the detected faults only after the last group of that pattern, then moves to the next pattern with the survivors.

Top module: `fault_word_sim`

## Requirements
- R1: After reset, `done` is 0 and `detMask` is all zeros.
- R2: Every net holds a WORD_W-bit word. Primary-input net n (n < PI_COUNT) is loaded with `pattern[n]` in every bit position, and all other nets are loaded with zero. Bit 0 of every word is never forced, so it follows the fault-free circuit.
- R3: Gate op codes on `tblOp` are applied bit by bit across the input words: 0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR, 5 NOT of source A, and 6 or 7 a copy of source A.
- R4: Fault slot s (1..WORD_W-1) sits at `faultGroup[(s-1)*SLOT_W +: SLOT_W]` with site index in bits [IDX_W-1:0], site kind in [IDX_W+1:IDX_W], stuck value in [IDX_W+2] and valid in [IDX_W+3]. Site kind 0 is a net, 1 is input A of a gate, 2 is input B of a gate, and 3 has no effect.
- R5: A net-site fault forces bit s of that net's word to the stuck value whenever the net is loaded or written, so every reader of the net sees it.
- R6: A pin-site fault forces bit s only on the named input of the named gate entry. Other readers of the same net see the unforced value.
- R7: `detMask[s-1]` is 1 exactly when some net marked in `poMask` differs in bit s from its own bit 0 at the end of the pass.
- R8: A slot whose valid bit is 0 never reports a detection.
- R9: `done` and the new `detMask` appear on the clock edge that is gateCount+2 edges after the edge that samples `start`. Both then hold until the next accepted start.
- R10: `start` is accepted only while idle, and accepting it clears `done` on the same edge. A `start` during a pass has no effect.
- R11: Table entries are evaluated in index order 0..gateCount-1, one per clock, so a later entry reads the words written by earlier ones.
- R12: With gateCount 0 no gate is evaluated, and the outputs reflect the loaded and forced net words only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tblWe | input | 1 | Gate table write enable |
| tblAddr | input | GIDX_W | Gate table entry to write |
| tblOp | input | 3 | Gate op code |
| tblSrcA | input | IDX_W | Net read as input A |
| tblSrcB | input | IDX_W | Net read as input B |
| tblDst | input | IDX_W | Net written by the gate |
| gateCount | input | GIDX_W+1 | Number of table entries to evaluate |
| poMask | input | NET_COUNT | Nets that are primary outputs |
| pattern | input | PI_COUNT | Input pattern bits |
| faultGroup | input | (WORD_W-1)*SLOT_W | Fault slot descriptors |
| start | input | 1 | Begin a pass |
| detMask | output | WORD_W-1 | Per-slot detected flags |
| done | output | 1 | Pass finished, results valid |

## Verification
A corrupted net word stays hidden until the capture edge. It then shows up at the ports as a wrong `detMask` bit, gateCount+2 cycles after `start`, and only when the corrupted bit lies on a path to a marked output. For this reason, groups are checked against a serial single-fault model with pattern and fault mixes that make each gate type, each site kind and each output path decisive. A wrong controller state shows up sooner and more directly: as a changed `done` latency, as a `detMask` change away from the rising edge of `done`, or as a restarted pass when `start` arrives during one.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NAND = 3'd2,
    OP_NOR  = 3'd3,
    OP_XOR  = 3'd4,
    OP_NOT  = 3'd5,
    OP_BUF  = 3'd6,
    OP_BUF2 = 3'd7
  } gate_op_e;

  typedef enum logic [1:0] {
    SITE_NET   = 2'd0,
    SITE_PIN_A = 2'd1,
    SITE_PIN_B = 2'd2,
    SITE_NONE  = 2'd3
  } site_kind_e;

  typedef struct packed {
    logic loadNets;
    logic evalGate;
    logic capture;
  } fws_ctl_t;

endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int MAX_GATES = 16,
  localparam int GIDX_W = $clog2(MAX_GATES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [GIDX_W:0]   gateCount,
  output fws_ctl_t          ctl,
  output logic [GIDX_W-1:0] gateIdx,
  output logic              done
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_EVAL, ST_CMP} state_e;

  localparam logic [GIDX_W:0]   ONE_WIDE = 1;
  localparam logic [GIDX_W-1:0] LAST_IDX = GIDX_W'(MAX_GATES - 1);

  state_e state;
  logic   lastGate;

  assign lastGate = (({1'b0, gateIdx} + ONE_WIDE) >= gateCount) || (gateIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gateIdx <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          done  <= 1'b0;
        end
        ST_LOAD: begin
          gateIdx <= '0;
          state   <= (gateCount == '0) ? ST_CMP : ST_EVAL;
        end
        ST_EVAL: begin
          if (lastGate) state <= ST_CMP;
          else gateIdx <= gateIdx + GIDX_W'(1);
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    ctl.loadNets = (state == ST_LOAD);
    ctl.evalGate = (state == ST_EVAL);
    ctl.capture  = (state == ST_CMP);
  end

endmodule

// File: rtl/fws_datapath.sv
module fws_datapath
  import fws_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NET_COUNT = 32,
  parameter int PI_COUNT  = 6,
  parameter int MAX_GATES = 16,
  localparam int IDX_W  = $clog2(NET_COUNT),
  localparam int GIDX_W = $clog2(MAX_GATES),
  localparam int SLOTS  = WORD_W - 1,
  localparam int SLOT_W = IDX_W + 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fws_ctl_t                ctl,
  input  logic [GIDX_W-1:0]       gateIdx,
  input  logic                    tblWe,
  input  logic [GIDX_W-1:0]       tblAddr,
  input  logic [2:0]              tblOp,
  input  logic [IDX_W-1:0]        tblSrcA,
  input  logic [IDX_W-1:0]        tblSrcB,
  input  logic [IDX_W-1:0]        tblDst,
  input  logic [PI_COUNT-1:0]     pattern,
  input  logic [NET_COUNT-1:0]    poMask,
  input  logic [SLOTS*SLOT_W-1:0] faultGroup,
  output logic [SLOTS-1:0]        detMask
);

  gate_op_e         opTbl  [MAX_GATES];
  logic [IDX_W-1:0] srcATbl[MAX_GATES];
  logic [IDX_W-1:0] srcBTbl[MAX_GATES];
  logic [IDX_W-1:0] dstTbl [MAX_GATES];

  logic [WORD_W-1:0] netWord[NET_COUNT];
  logic [WORD_W-1:0] loadVal[NET_COUNT];
  logic [WORD_W-1:0] sa0Net [NET_COUNT];
  logic [WORD_W-1:0] sa1Net [NET_COUNT];
  logic [WORD_W-1:0] pinA0, pinA1, pinB0, pinB1;
  logic [WORD_W-1:0] wordA, wordB, gateRes, poDiff;
  logic [IDX_W-1:0]  curDst;

  // Broadcast pattern bits across every machine; internal nets start at zero.
  for (genvar n = 0; n < NET_COUNT; n++) begin : g_load
    if (n < PI_COUNT) begin : g_pi
      assign loadVal[n] = {WORD_W{pattern[n]}};
    end else begin : g_inner
      assign loadVal[n] = '0;
    end
  end

  // Decode fault slots into per-net and per-pin forcing masks.
  always_comb begin
    for (int n = 0; n < NET_COUNT; n++) begin
      sa0Net[n] = '0;
      sa1Net[n] = '0;
    end
    pinA0 = '0; pinA1 = '0; pinB0 = '0; pinB1 = '0;
    for (int s = 1; s <= SLOTS; s++) begin
      logic [SLOT_W-1:0] fld;
      logic [IDX_W-1:0]  site;
      site_kind_e        kind;
      logic              stuck;
      fld   = faultGroup[(s-1)*SLOT_W +: SLOT_W];
      site  = fld[IDX_W-1:0];
      kind  = site_kind_e'(fld[IDX_W+1:IDX_W]);
      stuck = fld[IDX_W+2];
      if (fld[IDX_W+3]) begin
        case (kind)
          SITE_NET: begin
            if (stuck) sa1Net[site][s] = 1'b1;
            else       sa0Net[site][s] = 1'b1;
          end
          SITE_PIN_A: if (site == IDX_W'(gateIdx)) begin
            if (stuck) pinA1[s] = 1'b1;
            else       pinA0[s] = 1'b1;
          end
          SITE_PIN_B: if (site == IDX_W'(gateIdx)) begin
            if (stuck) pinB1[s] = 1'b1;
            else       pinB0[s] = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Word-wide gate evaluation with branch forcing on the inputs.
  always_comb begin
    wordA  = (netWord[srcATbl[gateIdx]] & ~pinA0) | pinA1;
    wordB  = (netWord[srcBTbl[gateIdx]] & ~pinB0) | pinB1;
    curDst = dstTbl[gateIdx];
    case (opTbl[gateIdx])
      OP_AND:  gateRes = wordA & wordB;
      OP_OR:   gateRes = wordA | wordB;
      OP_NAND: gateRes = ~(wordA & wordB);
      OP_NOR:  gateRes = ~(wordA | wordB);
      OP_XOR:  gateRes = wordA ^ wordB;
      OP_NOT:  gateRes = ~wordA;
      default: gateRes = wordA;
    endcase
  end

  // Any marked output whose faulty bit departs from its good bit.
  always_comb begin
    poDiff = '0;
    for (int n = 0; n < NET_COUNT; n++) begin
      if (poMask[n]) poDiff = poDiff | (netWord[n] ^ {WORD_W{netWord[n][0]}});
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < MAX_GATES; g++) begin
        opTbl[g]   <= OP_AND;
        srcATbl[g] <= '0;
        srcBTbl[g] <= '0;
        dstTbl[g]  <= '0;
      end
    end else if (tblWe) begin
      opTbl[tblAddr]   <= gate_op_e'(tblOp);
      srcATbl[tblAddr] <= tblSrcA;
      srcBTbl[tblAddr] <= tblSrcB;
      dstTbl[tblAddr]  <= tblDst;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NET_COUNT; n++) netWord[n] <= '0;
      detMask <= '0;
    end else begin
      if (ctl.loadNets) begin
        for (int n = 0; n < NET_COUNT; n++)
          netWord[n] <= (loadVal[n] & ~sa0Net[n]) | sa1Net[n];
      end else if (ctl.evalGate) begin
        netWord[curDst] <= (gateRes & ~sa0Net[curDst]) | sa1Net[curDst];
      end
      if (ctl.capture) detMask <= poDiff[WORD_W-1:1];
    end
  end

endmodule

// File: rtl/fault_word_sim.sv
module fault_word_sim
  import fws_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NET_COUNT = 32,
  parameter int PI_COUNT  = 6,
  parameter int MAX_GATES = 16,
  localparam int IDX_W  = $clog2(NET_COUNT),
  localparam int GIDX_W = $clog2(MAX_GATES),
  localparam int SLOTS  = WORD_W - 1,
  localparam int SLOT_W = IDX_W + 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tblWe,
  input  logic [GIDX_W-1:0]       tblAddr,
  input  logic [2:0]              tblOp,
  input  logic [IDX_W-1:0]        tblSrcA,
  input  logic [IDX_W-1:0]        tblSrcB,
  input  logic [IDX_W-1:0]        tblDst,
  input  logic [GIDX_W:0]         gateCount,
  input  logic [NET_COUNT-1:0]    poMask,
  input  logic [PI_COUNT-1:0]     pattern,
  input  logic [SLOTS*SLOT_W-1:0] faultGroup,
  input  logic                    start,
  output logic [SLOTS-1:0]        detMask,
  output logic                    done
);

  fws_ctl_t          ctl;
  logic [GIDX_W-1:0] gateIdx;

  fws_ctrl #(.MAX_GATES(MAX_GATES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .gateCount(gateCount),
    .ctl(ctl), .gateIdx(gateIdx), .done(done)
  );

  fws_datapath #(
    .WORD_W(WORD_W), .NET_COUNT(NET_COUNT), .PI_COUNT(PI_COUNT), .MAX_GATES(MAX_GATES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .gateIdx(gateIdx),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblOp(tblOp),
    .tblSrcA(tblSrcA), .tblSrcB(tblSrcB), .tblDst(tblDst),
    .pattern(pattern), .poMask(poMask), .faultGroup(faultGroup),
    .detMask(detMask)
  );

endmodule

// File: rtl/fws_chk.sv
module fws_chk
  import fws_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NET_COUNT = 32,
  parameter int MAX_GATES = 16,
  localparam int IDX_W  = $clog2(NET_COUNT),
  localparam int GIDX_W = $clog2(MAX_GATES),
  localparam int SLOTS  = WORD_W - 1,
  localparam int SLOT_W = IDX_W + 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    done,
  input logic [SLOTS-1:0]        detMask,
  input logic [SLOTS*SLOT_W-1:0] faultGroup,
  input logic [GIDX_W:0]         gateCount,
  input fws_ctl_t                ctl,
  input logic [GIDX_W-1:0]       gateIdx
);

  logic [SLOTS-1:0] validMask;

  always_comb begin
    for (int s = 0; s < SLOTS; s++) validMask[s] = faultGroup[s*SLOT_W + SLOT_W - 1];
  end

  p_clear_on_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (start && done) |=> !done)
    else $error("accepted start left done high");

  p_mask_only_at_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    (detMask != $past(detMask)) |-> $rose(done))
    else $error("detMask changed outside a pass completion");

  p_gate_in_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.evalGate |-> ({1'b0, gateIdx} < gateCount))
    else $error("evaluated a table entry beyond gateCount");

  p_idle_slots_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ((detMask & ~validMask) == '0))
    else $error("invalid slot reported a detection");

endmodule

bind fault_word_sim fws_chk #(
  .WORD_W(WORD_W), .NET_COUNT(NET_COUNT), .MAX_GATES(MAX_GATES)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .detMask(detMask),
  .faultGroup(faultGroup), .gateCount(gateCount), .ctl(ctl), .gateIdx(gateIdx)
);

// File: tb/fault_word_sim_tb.sv
`timescale 1ns/1ps
module fault_word_sim_tb;

  localparam int WORD_W = 16, NET_COUNT = 32, PI_COUNT = 6, MAX_GATES = 16;
  localparam int IDX_W = 5, GIDX_W = 4, SLOTS = 15, SLOT_W = 9;
  localparam int NGATES = 9, NFAULTS = 39;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rstN;
  logic                    tblWe;
  logic [GIDX_W-1:0]       tblAddr;
  logic [2:0]              tblOp;
  logic [IDX_W-1:0]        tblSrcA, tblSrcB, tblDst;
  logic [GIDX_W:0]         gateCount;
  logic [NET_COUNT-1:0]    poMask;
  logic [PI_COUNT-1:0]     pattern;
  logic [SLOTS*SLOT_W-1:0] faultGroup;
  logic                    start;
  logic [SLOTS-1:0]        detMask;
  logic                    done;

  fault_word_sim u_dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr), .tblOp(tblOp),
    .tblSrcA(tblSrcA), .tblSrcB(tblSrcB), .tblDst(tblDst), .gateCount(gateCount),
    .poMask(poMask), .pattern(pattern), .faultGroup(faultGroup), .start(start),
    .detMask(detMask), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  // Bench netlist: op, source A, source B, destination net.
  int gOp[NGATES] = '{0, 1, 2, 3, 4, 5, 0, 1, 6};
  int gA [NGATES] = '{0, 1, 6, 7, 8, 5, 10, 9, 13};
  int gB [NGATES] = '{1, 2, 3, 4, 9, 5, 11, 6, 13};
  int gD [NGATES] = '{6, 7, 8, 9, 10, 11, 12, 13, 14};
  logic [31:0] poBench = (32'd1 << 12) | (32'd1 << 14);

  int fKind[NFAULTS];
  int fIdx [NFAULTS];
  int fSv  [NFAULTS];

  typedef struct {
    logic [SLOTS-1:0] mask;
    int               startCyc;
    int               gc;
    string            tag;
  } exp_t;
  exp_t expQ[$];

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Serial single-fault reference: returns every net value.
  function automatic logic [31:0] simNets(logic [5:0] pat, int gc, bit fv, int kind, int idx, bit sv);
    logic [31:0] v;
    logic a, b, r;
    for (int n = 0; n < 32; n++) begin
      if (n < PI_COUNT) v[n] = pat[n];
      else v[n] = 1'b0;
    end
    if (fv && kind == 0) v[idx] = sv;
    for (int g = 0; g < gc; g++) begin
      a = v[gA[g]];
      b = v[gB[g]];
      if (fv && kind == 1 && idx == g) a = sv;
      if (fv && kind == 2 && idx == g) b = sv;
      case (gOp[g])
        0: r = a & b;
        1: r = a | b;
        2: r = ~(a & b);
        3: r = ~(a | b);
        4: r = a ^ b;
        5: r = ~a;
        default: r = a;
      endcase
      if (fv && kind == 0 && idx == gD[g]) r = sv;
      v[gD[g]] = r;
    end
    return v;
  endfunction

  function automatic bit detects(logic [5:0] pat, int gc, int f);
    logic [31:0] good, bad;
    good = simNets(pat, gc, 1'b0, 0, 0, 1'b0);
    bad  = simNets(pat, gc, 1'b1, fKind[f], fIdx[f], fSv[f][0]);
    return |((good ^ bad) & poBench);
  endfunction

  // Driver: builds a group, pushes the expected result, pulses start.
  task automatic runGroup(input logic [5:0] pat, input int gc, input int slotF[SLOTS],
                          input bit poke, input string tag, output logic [SLOTS-1:0] expMask);
    logic [SLOTS*SLOT_W-1:0] fg;
    exp_t e;
    bit wasDone;
    fg = '0;
    expMask = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slotF[s] >= 0) begin
        fg[s*SLOT_W +: SLOT_W] = {1'b1, 1'(fSv[slotF[s]]), 2'(fKind[slotF[s]]), 5'(fIdx[slotF[s]])};
        expMask[s] = detects(pat, gc, slotF[s]);
      end
    end
    @(negedge clk);
    pattern = pat;
    gateCount = 5'(gc);
    faultGroup = fg;
    e.mask = expMask;
    e.startCyc = cyc;
    e.gc = gc;
    e.tag = tag;
    expQ.push_back(e);
    wasDone = done;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (wasDone) check(done == 1'b0, "R10 accepted start clears done", 32'(done), 0);
    if (poke) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // Monitor: pops one expected item per rising done.
  initial begin
    bit seen;
    seen = 1'b0;
    forever begin
      @(negedge clk);
      if (done && !seen) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 done without a pending pass", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(detMask == e.mask, e.tag, 32'(detMask), 32'(e.mask));
          check((cyc - e.startCyc) == e.gc + 3, "R9 done latency", 32'(cyc - e.startCyc), 32'(e.gc + 3));
        end
      end
      seen = done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int slots[SLOTS];
    logic [SLOTS-1:0] m;
    bit dropped[NFAULTS];
    bit newDet[NFAULTS];
    int pending[$];
    logic [5:0] pat;

    rstN = 1'b0; start = 1'b0; tblWe = 1'b0; tblAddr = '0; tblOp = '0;
    tblSrcA = '0; tblSrcB = '0; tblDst = '0; gateCount = '0; poMask = '0;
    pattern = '0; faultGroup = '0;
    for (int f = 0; f < 30; f++) begin
      fKind[f] = 0; fIdx[f] = f >> 1; fSv[f] = f & 1;
    end
    fKind[30] = 1; fIdx[30] = 1; fSv[30] = 0;
    fKind[31] = 1; fIdx[31] = 1; fSv[31] = 1;
    fKind[32] = 2; fIdx[32] = 0; fSv[32] = 0;
    fKind[33] = 2; fIdx[33] = 0; fSv[33] = 1;
    fKind[34] = 1; fIdx[34] = 7; fSv[34] = 0;
    fKind[35] = 2; fIdx[35] = 7; fSv[35] = 1;
    fKind[36] = 2; fIdx[36] = 4; fSv[36] = 1;
    fKind[37] = 1; fIdx[37] = 6; fSv[37] = 0;
    fKind[38] = 3; fIdx[38] = 12; fSv[38] = 1;
    for (int f = 0; f < NFAULTS; f++) dropped[f] = 1'b0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", 32'(done), 0);
    check(detMask == '0, "R1 detMask after reset", 32'(detMask), 0);

    // R11: program the table in level order.
    for (int g = 0; g < NGATES; g++) begin
      @(negedge clk);
      tblWe = 1'b1; tblAddr = 4'(g); tblOp = 3'(gOp[g]);
      tblSrcA = 5'(gA[g]); tblSrcB = 5'(gB[g]); tblDst = 5'(gD[g]);
    end
    @(negedge clk);
    tblWe = 1'b0;
    poMask = poBench;

    // R5: stem faults on nets 0..7.
    for (int s = 0; s < SLOTS; s++) slots[s] = s;
    runGroup(6'b101101, NGATES, slots, 1'b0, "R5 stem fault group", m);

    // R6: branch faults only; R10: a second start mid-pass is ignored.
    for (int s = 0; s < SLOTS; s++) slots[s] = (s < 8) ? 30 + s : -1;
    runGroup(6'b010111, NGATES, slots, 1'b1, "R6 branch fault group", m);
    for (int s = 0; s < SLOTS; s++) slots[s] = (s < 8) ? 30 + s : -1;
    runGroup(6'b111011, NGATES, slots, 1'b0, "R6 branch fault group alt", m);

    // R4: site kind 3 in slot 1 must stay quiet beside real stem faults.
    for (int s = 0; s < SLOTS; s++) slots[s] = -1;
    slots[0] = 38; slots[1] = 24; slots[2] = 25; slots[3] = 28; slots[4] = 29;
    runGroup(6'b000000, NGATES, slots, 1'b0, "R4 unused site kind", m);
    check(detMask[0] == 1'b0, "R4 kind 3 slot quiet", 32'(detMask[0]), 0);

    // R8: partially filled group; R9: result held while idle.
    for (int s = 0; s < SLOTS; s++) slots[s] = (s < 5) ? 20 + s : -1;
    runGroup(6'b110001, NGATES, slots, 1'b0, "R8 invalid slots quiet", m);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && detMask == m, "R9 result held after done", 32'(detMask), 32'(m));

    // R12: zero gates, only loaded and forced words reach the outputs.
    for (int s = 0; s < SLOTS; s++) slots[s] = (s < 6) ? 24 + s : -1;
    runGroup(6'b111111, 0, slots, 1'b0, "R12 empty gate list", m);

    // R2 R3 R7 R11: full flow, groups of 15, drop after the pattern's last group.
    pat = 6'b100111;
    for (int p = 0; p < 10; p++) begin
      pending.delete();
      for (int f = 0; f < NFAULTS; f++) begin
        newDet[f] = 1'b0;
        if (!dropped[f]) pending.push_back(f);
      end
      for (int base = 0; base < pending.size(); base += SLOTS) begin
        for (int s = 0; s < SLOTS; s++) slots[s] = (base + s < pending.size()) ? pending[base + s] : -1;
        runGroup(pat, NGATES, slots, 1'b0, "R2 R3 R7 R11 word evaluation group", m);
        for (int s = 0; s < SLOTS; s++) if (slots[s] >= 0 && m[s]) newDet[slots[s]] = 1'b1;
      end
      for (int f = 0; f < NFAULTS; f++) if (newDet[f]) dropped[f] = 1'b1;
      pat = {pat[4:0], pat[5] ^ pat[4]};
    end

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule